// File: doc/BRIEF.md
# Single-Slope Converter Digital Back End

This block holds the digital side of a bank of column-parallel single-slope converters. A single counter, shared by every channel, steps through a 9-bit Gray sequence while an external ramp sweeps. Each channel has one comparator-trip input. The first time that input is high during a conversion window, the channel stores the counter value present in that cycle. A channel whose comparator stays low for the whole window stores the full-scale code.

When the window closes, every channel moves its stored value into a second rank of registers. That rank holds the result steady for the whole of the next conversion, so a serializer can drain one sample while the next one converts. The output path turns the stored Gray value back into plain binary. A one-cycle strobe marks the cycle in which fresh results first appear.

A synchronous start pulse opens a window. It clears the counter and every channel's captured state. It also restarts a window that is already in progress.

Top module: `ssadc_backend`

## Requirements
- R1: After reset, `done_o` and `busy_o` are low and every channel field of `dout_o` reads zero.
- R2: While a window runs, successive values of the shared counter differ in exactly one bit, because the count is kept in Gray code.
- R3: A window lasts exactly 512 clock cycles. If `start_i` is sampled high at clock edge E, `done_o` is high in the cycle after edge E+512 and low in the cycle after that.
- R4: Busy cycles are numbered k = 0..511, and cycle 0 is the first cycle after the start edge. When a channel's trip input is first high in cycle k, that channel reports binary value k. Channel c occupies bits [9c+8:9c] of `dout_o`.
- R5: Only the first trip in a window is stored. Later high levels or pulses on the same trip input in that window do not change the reported value.
- R6: A channel whose trip input stays low for the whole window reports 511 (all ones).
- R7: `dout_o` changes only in the cycle where `done_o` is high. It stays stable through the whole of the following conversion.
- R8: `done_o` is a single-cycle pulse.
- R9: A `start_i` pulse during a running window restarts the count at zero and clears every channel's captured state. A trip seen before the restart has no effect on the result, and no `done_o` pulse is produced for the abandoned window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Opens, or restarts, a conversion window |
| trip_i | input | N_CH | Comparator trip per channel |
| busy_o | output | 1 | High while a window is counting |
| done_o | output | 1 | One-cycle strobe: new results are on dout_o |
| dout_o | output | N_CH*9 | Binary results, channel c in bits [9c+8:9c] |

## Verification
The bench places trips at count 0, at count 511 and never, and checks these boundaries. A design with an off-by-one in the counter or the window would shift every code, or would lose the all-ones default. Some channels get extra pulses after their first trip, and others hold a steady level. A capture that is not locked after the first trip would report a later count. The bench also samples the outputs mid-way through a conversion to check that the previous results stay put. It restarts a window part-way through to check that a stale early trip is discarded and that no strobe appears for the abandoned window.

// File: rtl/ssadc_pkg.sv
package ssadc_pkg;
    localparam int CODE_W = 9;
    localparam int STEPS  = 1 << CODE_W;

    typedef logic [CODE_W-1:0] code_t;

    localparam code_t CODE_MAX = code_t'(STEPS - 1);

    function automatic code_t bin2gray(input code_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic code_t gray2bin(input code_t g);
        code_t b;
        b[CODE_W-1] = g[CODE_W-1];
        for (int i = CODE_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    localparam code_t GRAY_FULL = bin2gray(CODE_MAX);
endpackage

// File: rtl/ssadc_seq.sv
module ssadc_seq
    import ssadc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_i,
    output code_t gray_o,
    output logic  busy_o,
    output logic  last_o,
    output logic  done_o
);
    code_t cnt_q;
    code_t gray_q;
    logic  busy_q;
    logic  done_q;

    assign last_o = busy_q && (cnt_q == CODE_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            gray_q <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= last_o && !start_i;
            if (start_i) begin
                cnt_q  <= '0;
                gray_q <= '0;
                busy_q <= 1'b1;
            end else if (busy_q) begin
                if (cnt_q == CODE_MAX) begin
                    busy_q <= 1'b0;
                end else begin
                    cnt_q  <= cnt_q + 1'b1;
                    gray_q <= bin2gray(cnt_q + 1'b1);
                end
            end
        end
    end

    assign gray_o = gray_q;
    assign busy_o = busy_q;
    assign done_o = done_q;

    // R2: adjacent counter states differ in one bit
    p_gray_step_r2: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q) && !$past(start_i)) |-> ($countones(gray_q ^ $past(gray_q)) == 1));

    // R8: strobe lasts one cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R3: strobe only follows a counting cycle
    p_done_after_busy_r3: assert property (@(posedge clk) disable iff (rst)
        done_q |-> ($past(busy_q) && !busy_q));
endmodule

// File: rtl/ssadc_lane.sv
module ssadc_lane
    import ssadc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_i,
    input  logic  busy_i,
    input  logic  last_i,
    input  code_t gray_i,
    input  logic  trip_i,
    output code_t code_o
);
    logic  hit_q;
    code_t grab_q;
    code_t hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q  <= 1'b0;
            grab_q <= '0;
            hold_q <= '0;
        end else if (start_i) begin
            hit_q  <= 1'b0;
            grab_q <= '0;
        end else if (busy_i) begin
            if (trip_i && !hit_q) begin
                hit_q  <= 1'b1;
                grab_q <= gray_i;
            end
            if (last_i) begin
                hold_q <= hit_q ? grab_q : (trip_i ? gray_i : GRAY_FULL);
            end
        end
    end

    assign code_o = gray2bin(hold_q);

    // R5: once captured, first-stage value is frozen until restart
    p_first_trip_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(hit_q) && !$past(start_i)) |-> $stable(grab_q));

    // R9: a restart clears the captured flag
    p_restart_clear_r9: assert property (@(posedge clk) disable iff (rst)
        $past(start_i) |-> !hit_q);
endmodule

// File: rtl/ssadc_backend.sv
module ssadc_backend
    import ssadc_pkg::*;
#(
    parameter int N_CH = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_i,
    input  logic [N_CH-1:0]        trip_i,
    output logic                   busy_o,
    output logic                   done_o,
    output logic [N_CH*CODE_W-1:0] dout_o
);
    code_t gray_w;
    logic  last_w;

    ssadc_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .gray_o  (gray_w),
        .busy_o  (busy_o),
        .last_o  (last_w),
        .done_o  (done_o)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_lane
        ssadc_lane u_lane (
            .clk     (clk),
            .rst     (rst),
            .start_i (start_i),
            .busy_i  (busy_o),
            .last_i  (last_w),
            .gray_i  (gray_w),
            .trip_i  (trip_i[c]),
            .code_o  (dout_o[c*CODE_W +: CODE_W])
        );
    end

    // R7: results move only alongside the strobe
    p_hold_stable_r7: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(dout_o));
endmodule

// File: tb/ssadc_backend_bench.sv
module ssadc_backend_bench;
    import ssadc_pkg::*;
    localparam int N = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic [N-1:0] trip_i = '0;
    logic busy_o, done_o;
    logic [N*CODE_W-1:0] dout_o;

    int checks = 0;
    int errors = 0;
    int tgt [N];
    int expv [N];
    int prev [N];

    always #10 clk = ~clk;

    ssadc_backend #(.N_CH(N)) u_ssadc_backend (
        .clk(clk), .rst(rst), .start_i(start_i), .trip_i(trip_i),
        .busy_o(busy_o), .done_o(done_o), .dout_o(dout_o)
    );

    function automatic int model(input int t);
        return (t < STEPS) ? t : STEPS - 1;
    endfunction

    task automatic chk(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic check_all(input string req, input int ev [N]);
        for (int c = 0; c < N; c++)
            chk(req, int'(dout_o[c*CODE_W +: CODE_W]), ev[c]);
    endtask

    // mode 0: level held from target on; mode 1: pulse at target plus later noise
    task automatic run_conv(input int mode);
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        for (int m = 0; m < STEPS; m++) begin
            for (int c = 0; c < N; c++) begin
                if (mode == 0) trip_i[c] = (m >= tgt[c]);
                else trip_i[c] = (m == tgt[c]) || ((m > tgt[c]) && ($urandom % 3 == 0));
            end
            if (m == 200) begin
                check_all("R7 hold during next conversion", prev);
                chk("R3 busy during window", int'(busy_o), 1);
            end
            if (m > 0) chk("R8 no early done", int'(done_o), 0);
            @(negedge clk);
        end
        trip_i = '0;
        chk("R3 done after 512 cycles", int'(done_o), 1);
        for (int c = 0; c < N; c++) expv[c] = model(tgt[c]);
        check_all((mode == 0) ? "R4 R6 captured codes" : "R5 first trip only", expv);
        prev = expv;
        @(negedge clk);
        chk("R8 done single cycle", int'(done_o), 0);
        check_all("R7 stable after done", expv);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(1234);
        for (int c = 0; c < N; c++) prev[c] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset done", int'(done_o), 0);
        chk("R1 reset busy", int'(busy_o), 0);
        check_all("R1 reset data", prev);

        // directed boundaries: 0, 511, never, 1, 510, mid values
        tgt = '{0, 511, 600, 1, 510, 256, 255, 512};
        run_conv(0);
        tgt = '{3, 0, 700, 100, 511, 42, 300, 9};
        run_conv(1);

        // random rounds
        for (int r = 0; r < 6; r++) begin
            for (int c = 0; c < N; c++) tgt[c] = $urandom % 560;
            run_conv(r % 2);
        end

        // R9: restart mid-window discards an early trip
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        trip_i = '1;
        @(negedge clk); trip_i = '0;
        repeat (40) @(negedge clk);
        for (int c = 0; c < N; c++) tgt[c] = (c % 2 == 0) ? 900 : 77 + c;
        run_conv(0);
        chk("R9 no extra done", int'(done_o), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule